// File: doc/BRIEF.md
# Transfer-to-burst beat slicer

This block accepts one transfer request (a direction, a start address, a byte count written as bytes minus one, and a fixed-address flag). It turns that request into a series of bus-master pieces. No piece carries more than a parameterised maximum number of bytes. Every piece except the last carries exactly that maximum, and the last piece carries whatever remains.

Each piece is announced on the read port or the write port with a one-cycle request, and only while the fabric shows grant. After the request, the block waits for the fabric's per-piece done strobe before it arms the next piece. Unless the fixed-address flag is set, a piece's address is the start address plus the bytes already moved. When the final piece is done, the block raises a single-cycle completion pulse. Moving the data and decoding descriptors are left to neighbouring logic.

Top module: `beat_slicer`

## Requirements
- R1: The start size input encodes the total byte count minus one. The byte sizes of all pieces of one transfer sum to size plus one.
- R2: The piece size output is encoded as bytes minus one. While more than MAX_BEAT bytes remain, a piece carries exactly MAX_BEAT bytes, and the final piece carries the remainder. With the default of 16, totals of 13, 16 and 19 bytes yield one, one and two pieces.
- R3: With the fixed-address flag at 0, each piece's address equals the start address plus the bytes moved by earlier pieces of the same transfer.
- R4: With the fixed-address flag at 1, every piece's address equals the start address. This includes totals below one 4-byte word.
- R5: A piece request is high for exactly one cycle, only after the selected direction's grant was seen high on the previous clock edge. No further request is issued until that direction's done input has been seen high.
- R6: The completion output is high for exactly one cycle. It is visible in the cycle after the clock edge that samples done for the final piece, and it is never high at any other time.
- R7: Direction is captured at start (0 = read, 1 = write). Only that port carries requests. The other port's request, address and size outputs stay at zero, and both ports are zero while idle.
- R8: A start pulse that arrives while a transfer is in progress is ignored. It changes neither the pieces of the ongoing transfer nor the activity after completion.
- R9: After reset, busy, both requests and the completion output are low.
- R10: Busy goes high in the cycle after an accepted start and stays high through the completion cycle. It falls in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle start of a transfer |
| startDir | input | 1 | 0 read, 1 write |
| startAddr | input | AW | First byte address |
| startSize | input | SW | Total bytes minus one |
| startFix | input | 1 | Hold the address for all pieces |
| busy | output | 1 | Transfer in progress |
| xferDone | output | 1 | One-cycle completion pulse |
| rdReq | output | 1 | Read piece request |
| rdAddr | output | AW | Read piece address |
| rdSizeM1 | output | SW | Read piece bytes minus one |
| rdGrant | input | 1 | Read port may accept a request |
| rdDone | input | 1 | Read piece finished |
| wrReq | output | 1 | Write piece request |
| wrAddr | output | AW | Write piece address |
| wrSizeM1 | output | SW | Write piece bytes minus one |
| wrGrant | input | 1 | Write port may accept a request |
| wrDone | input | 1 | Write piece finished |

## Verification
On every cycle, the assertions check the following: requests are single-cycle and follow a seen grant, the completion pulse never lasts two cycles, a piece never exceeds the maximum, a held address does not move between pieces, and the latched direction cannot change outside a start. The bench scenarios are what show the rest. These cover the exact split of totals just below, at and above the maximum, the running address sums, word-fraction fixed transfers, the timing of completion after the last done, and a start pulse that is discarded during a transfer.

// File: rtl/slicer_pkg.sv
package slicer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_PULSE,
    ST_WAIT,
    ST_FIN
  } slicerStateT;

  typedef struct packed {
    logic load;
    logic advance;
  } slicerStrobeT;

endpackage

// File: rtl/slicer_datapath.sv
module slicer_datapath
  import slicer_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int MAX_BEAT = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  slicerStrobeT  strobe,
  input  logic          startDir,
  input  logic [AW-1:0] startAddr,
  input  logic [SW-1:0] startSize,
  input  logic          startFix,
  output logic          dirQ,
  output logic          lastPiece,
  output logic [AW-1:0] pieceAddr,
  output logic [SW-1:0] pieceSizeM1
);
  localparam int CW = SW + 1;
  localparam logic [CW-1:0] MAXC = CW'(MAX_BEAT);

  logic [AW-1:0] baseQ;
  logic [CW-1:0] offQ;
  logic [CW-1:0] remQ;
  logic          fixQ;
  logic [CW-1:0] curBytes;

  // bytes of the piece now pending: capped at the maximum beat
  always_comb begin
    curBytes  = (remQ > MAXC) ? MAXC : remQ;
    lastPiece = (remQ <= MAXC);
    pieceAddr = fixQ ? baseQ : baseQ + AW'(offQ);
    pieceSizeM1 = SW'(curBytes - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ <= '0;
      offQ  <= '0;
      remQ  <= '0;
      fixQ  <= 1'b0;
      dirQ  <= 1'b0;
    end else if (strobe.load) begin
      baseQ <= startAddr;
      offQ  <= '0;
      remQ  <= {1'b0, startSize} + CW'(1);
      fixQ  <= startFix;
      dirQ  <= startDir;
    end else if (strobe.advance) begin
      offQ  <= offQ + curBytes;
      remQ  <= remQ - curBytes;
    end
  end

  // R2
  piece_max_chk: assert property (@(posedge clk) disable iff (!rstN)
    (remQ != '0) |-> (pieceSizeM1 < SW'(MAX_BEAT)));

  // R4
  fix_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fixQ && strobe.advance) |=> $stable(pieceAddr));

  // R7
  dir_latched_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(dirQ));

endmodule

// File: rtl/slicer_ctrl.sv
module slicer_ctrl
  import slicer_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  input  logic         lastPiece,
  input  logic         pieceGrant,
  input  logic         pieceDone,
  output slicerStrobeT strobe,
  output logic         pieceReq,
  output logic         busy,
  output logic         xferDone
);
  slicerStateT stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (startReq) begin
        strobe.load = 1'b1;
        stateD = ST_ARM;
      end
      ST_ARM:   if (pieceGrant) stateD = ST_PULSE;
      ST_PULSE: stateD = ST_WAIT;
      ST_WAIT: if (pieceDone) begin
        strobe.advance = 1'b1;
        stateD = lastPiece ? ST_FIN : ST_ARM;
      end
      ST_FIN:  stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign pieceReq = (stateQ == ST_PULSE);
  assign busy     = (stateQ != ST_IDLE);
  assign xferDone = (stateQ == ST_FIN);

  // R5
  req_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    pieceReq |-> $past(pieceGrant));

  // R5
  req_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    pieceReq |=> !pieceReq);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferDone |=> !xferDone);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !xferDone) |=> busy);

endmodule

// File: rtl/beat_slicer.sv
module beat_slicer
  import slicer_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int MAX_BEAT = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          startDir,
  input  logic [AW-1:0] startAddr,
  input  logic [SW-1:0] startSize,
  input  logic          startFix,
  output logic          busy,
  output logic          xferDone,
  output logic          rdReq,
  output logic [AW-1:0] rdAddr,
  output logic [SW-1:0] rdSizeM1,
  input  logic          rdGrant,
  input  logic          rdDone,
  output logic          wrReq,
  output logic [AW-1:0] wrAddr,
  output logic [SW-1:0] wrSizeM1,
  input  logic          wrGrant,
  input  logic          wrDone
);
  slicerStrobeT  strobe;
  logic          dirQ;
  logic          lastPiece;
  logic [AW-1:0] pieceAddr;
  logic [SW-1:0] pieceSizeM1;
  logic          pieceReq;
  logic          pieceGrant;
  logic          pieceDone;
  logic          rdSel;
  logic          wrSel;

  assign pieceGrant = dirQ ? wrGrant : rdGrant;
  assign pieceDone  = dirQ ? wrDone  : rdDone;
  assign rdSel      = busy && !dirQ;
  assign wrSel      = busy && dirQ;

  slicer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startReq   (startReq),
    .lastPiece  (lastPiece),
    .pieceGrant (pieceGrant),
    .pieceDone  (pieceDone),
    .strobe     (strobe),
    .pieceReq   (pieceReq),
    .busy       (busy),
    .xferDone   (xferDone)
  );

  slicer_datapath #(.AW(AW), .SW(SW), .MAX_BEAT(MAX_BEAT)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .startDir    (startDir),
    .startAddr   (startAddr),
    .startSize   (startSize),
    .startFix    (startFix),
    .dirQ        (dirQ),
    .lastPiece   (lastPiece),
    .pieceAddr   (pieceAddr),
    .pieceSizeM1 (pieceSizeM1)
  );

  assign rdReq    = pieceReq && rdSel;
  assign wrReq    = pieceReq && wrSel;
  assign rdAddr   = rdSel ? pieceAddr   : '0;
  assign rdSizeM1 = rdSel ? pieceSizeM1 : '0;
  assign wrAddr   = wrSel ? pieceAddr   : '0;
  assign wrSizeM1 = wrSel ? pieceSizeM1 : '0;

endmodule

// File: tb/beat_slicer_tb_top.sv
module beat_slicer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 16;
  localparam int MAXB = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0, startDir = 1'b0, startFix = 1'b0;
  logic [AW-1:0] startAddr = '0;
  logic [SW-1:0] startSize = '0;
  logic busy, xferDone;
  logic rdReq, wrReq;
  logic [AW-1:0] rdAddr, wrAddr;
  logic [SW-1:0] rdSizeM1, wrSizeM1;
  logic rdGrant = 1'b1, wrGrant = 1'b1, rdDone = 1'b0, wrDone = 1'b0;

  int checks = 0;
  int errors = 0;
  logic curDir = 1'b0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beat_slicer #(.AW(AW), .SW(SW), .MAX_BEAT(MAXB)) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startDir(startDir),
    .startAddr(startAddr), .startSize(startSize), .startFix(startFix),
    .busy(busy), .xferDone(xferDone),
    .rdReq(rdReq), .rdAddr(rdAddr), .rdSizeM1(rdSizeM1), .rdGrant(rdGrant), .rdDone(rdDone),
    .wrReq(wrReq), .wrAddr(wrAddr), .wrSizeM1(wrSizeM1), .wrGrant(wrGrant), .wrDone(wrDone)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison of the inactive port against the model (R7)
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (!busy || curDir) begin
        check(!rdReq && rdAddr == 0 && rdSizeM1 == 0, "R7 read port idle", rdAddr, 0);
      end
      if (!busy || !curDir) begin
        check(!wrReq && wrAddr == 0 && wrSizeM1 == 0, "R7 write port idle", wrAddr, 0);
      end
    end
  end

  function automatic logic getReq(input logic d);
    return d ? wrReq : rdReq;
  endfunction

  task automatic setGrant(input logic d, input logic v);
    if (d) wrGrant = v; else rdGrant = v;
  endtask

  task automatic setDone(input logic d, input logic v);
    if (d) wrDone = v; else rdDone = v;
  endtask

  task automatic runXfer(input logic d, input logic [AW-1:0] a, input int totalBytes,
                         input logic fx, input bit holdGrant, input bit noisyStart);
    int expAddr[$];
    int expBytes[$];
    int left = totalBytes;
    int sent = 0;
    int sumBytes = 0;
    while (left > 0) begin
      int b = (left > MAXB) ? MAXB : left;
      expAddr.push_back(fx ? int'(a) : int'(a) + sent);
      expBytes.push_back(b);
      sent += b;
      left -= b;
    end
    curDir = d;
    if (holdGrant) setGrant(d, 1'b0);
    @(negedge clk);
    startReq = 1'b1; startDir = d; startAddr = a;
    startSize = SW'(totalBytes - 1); startFix = fx;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1, "R10 busy after start", busy, 1);
    if (noisyStart) begin
      startReq = 1'b1; startDir = ~d; startAddr = a + 32'h100;
      startSize = SW'(60); startFix = ~fx;
      @(negedge clk);
      startReq = 1'b0;
    end
    if (holdGrant) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(getReq(d) == 1'b0, "R5 no request without grant", getReq(d), 0);
      end
      setGrant(d, 1'b1);
    end
    for (int i = 0; i < expAddr.size(); i++) begin
      int waitCnt = 0;
      logic [AW-1:0] gotA;
      logic [SW-1:0] gotS;
      while (getReq(d) !== 1'b1 && waitCnt < 50) begin
        @(negedge clk);
        waitCnt++;
      end
      check(getReq(d) == 1'b1, "R5 piece request seen", getReq(d), 1);
      gotA = d ? wrAddr : rdAddr;
      gotS = d ? wrSizeM1 : rdSizeM1;
      check(gotA == AW'(expAddr[i]), fx ? "R4 held address" : "R3 advancing address",
            gotA, expAddr[i]);
      check(int'(gotS) == expBytes[i] - 1, "R2 piece size", gotS, expBytes[i] - 1);
      sumBytes += int'(gotS) + 1;
      setGrant(d, 1'b0);
      @(negedge clk);
      check(getReq(d) == 1'b0, "R5 request lasts one cycle", getReq(d), 0);
      for (int k = 0; k < 1 + (i % 3); k++) begin
        @(negedge clk);
        check(getReq(d) == 1'b0, "R5 no request before done", getReq(d), 0);
      end
      setDone(d, 1'b1);
      @(negedge clk);
      setDone(d, 1'b0);
      setGrant(d, 1'b1);
      check(xferDone == (i == expAddr.size() - 1), "R6 completion timing", xferDone,
            (i == expAddr.size() - 1));
      check(busy == 1'b1, "R10 busy through completion", busy, 1);
    end
    @(negedge clk);
    check(xferDone == 1'b0, "R6 completion single cycle", xferDone, 0);
    check(busy == 1'b0, "R10 busy falls", busy, 0);
    check(sumBytes == totalBytes, "R1 byte total", sumBytes, totalBytes);
    if (noisyStart) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        check(!rdReq && !wrReq && !busy, "R8 start ignored while busy", busy, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !rdReq && !wrReq && !xferDone, "R9 reset state", busy, 0);
    runXfer(1'b0, 32'h0200_0000, 16, 1'b0, 0, 0);   // equal to max
    runXfer(1'b1, 32'h0200_0040, 13, 1'b0, 0, 0);   // below max
    runXfer(1'b0, 32'h0200_0080, 19, 1'b0, 0, 0);   // above max
    runXfer(1'b1, 32'h0300_0000, 3,  1'b1, 0, 0);   // fixed, under a word
    runXfer(1'b0, 32'h0300_0010, 4,  1'b1, 0, 0);
    runXfer(1'b0, 32'h0300_0020, 15, 1'b1, 0, 0);
    runXfer(1'b1, 32'h0400_0000, 50, 1'b1, 0, 0);
    runXfer(1'b0, 32'h0500_0004, 40, 1'b0, 1, 0);
    runXfer(1'b1, 32'h0600_0000, 35, 1'b0, 0, 1);
    runXfer(1'b0, 32'h0700_0000, 1,  1'b0, 0, 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule